// File: doc/BRIEF.md
# Window Watchdog Edge-Interval Checker

This block supervises a microcontroller through one trigger line that the software toggles at a steady rate. A slow system clock, nominally between 4 kHz and 24 kHz, samples the line through a synchroniser. The block counts the clock cycles between each edge and the next edge of opposite polarity. This half-period is compared against a lower and an upper window limit, both given in clock cycles. An interval that is too short, too long, or a line that stops toggling raises a failure request.

The failure request, and the matching recovery request, drive a separate delay counter that owns the actual fault output. That output is fed back to this block. While the fault output is active, the block issues a recovery request only after a run of consecutive intervals that lie strictly inside the window. Any bad interval breaks the run and starts it over. Pulling the enable input low holds all supervision state in reset.

Top module: `wdg_window_monitor`

## Requirements
- R1: While reset is applied, and right after it, `fail_req` and `ok_req` are low and the interval and run counters are zero.
- R2: The trigger passes through a two-stage synchroniser. The measured interval equals the number of clock cycles between two toggles of `trig_in`, and every toggle counts as an edge whichever its polarity.
- R3: If HI_CYC cycles pass without an edge, `fail_req` is set. A missing trigger and an interval of HI_CYC or more both count as too long.
- R4: An interval of LO_CYC cycles or fewer sets `fail_req`.
- R5: An interval with LO_CYC < interval < HI_CYC is good and never sets `fail_req`.
- R6: The interval counter saturates at HI_CYC and does not wrap. An arbitrarily long silence is therefore never taken for a good interval.
- R7: GOOD_RUN (default 16) consecutive good intervals clear `fail_req`. `ok_req` is high while `en` is high, `fault_out_on` is high and the run is complete. `fail_req` and `ok_req` are never high together.
- R8: Any bad interval resets the run to zero, so a full new run of GOOD_RUN good intervals is needed afterwards.
- R9: While `en` is low, the counters and `fail_req` are held at zero, `ok_req` is low, and trigger activity has no effect.
- R10: The first edge after `en` rises only starts the timer and is not classified. The no-edge timeout still applies from the moment of enable.
- R11: With `fault_out_on` low, `ok_req` stays low even when the run is complete, while `fail_req` still clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Supervision enable; low holds the block in reset |
| trig_in | input | 1 | Asynchronous trigger line from the microcontroller |
| fault_out_on | input | 1 | Current state of the downstream fault output |
| fail_req | output | 1 | Failure request to the delay counter |
| ok_req | output | 1 | Recovery request to the delay counter |

## Verification
The assertions check on every cycle that the interval counter never passes its ceiling and that the run counter never passes GOOD_RUN. They also check that a timeout cycle is followed by an active failure request, that failure and recovery requests never overlap, and that a low enable clears the state on the next edge. The bench scenarios are the only evidence of the window classification at its exact boundaries (LO_CYC, LO_CYC+1, HI_CYC-1, HI_CYC). They also cover the run being broken and restarted, the unclassified first edge after enable, the gating by the fault-output state, and the absence of wrap-around after a long silence.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    // Classification of one clock cycle by the interval measurer
    typedef enum logic [1:0] {
        IV_NONE = 2'd0,
        IV_GOOD = 2'd1,
        IV_BAD  = 2'd2
    } ivl_verdict_e;

endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic edge_o
);
    // sync_q[STAGES-1] is the synchronised level; sync_q[STAGES] is its previous value
    typedef struct packed {
        logic [STAGES:0] sync;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-1:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign edge_o = st_q.sync[STAGES] ^ st_q.sync[STAGES-1];

endmodule

// File: rtl/wdg_interval.sv
module wdg_interval
    import wdg_pkg::*;
#(
    parameter int LO_CYC = 26,
    parameter int HI_CYC = 89,
    localparam int CW = $clog2(HI_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          edge_i,
    output ivl_verdict_e  verdict_o,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] LO_V = CW'(LO_CYC);
    localparam logic [CW-1:0] HI_V = CW'(HI_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          armed;
    } ivl_state_t;

    ivl_state_t   st_d, st_q;
    ivl_verdict_e verdict_d;

    always_comb begin
        st_d      = st_q;
        verdict_d = IV_NONE;
        if (!en) begin
            st_d = '0;
        end else if (edge_i) begin
            if (st_q.armed) begin
                verdict_d = (st_q.cnt > LO_V && st_q.cnt < HI_V) ? IV_GOOD : IV_BAD;
            end
            st_d.cnt   = CW'(1);
            st_d.armed = 1'b1;
        end else if (st_q.cnt == HI_V) begin
            // silence reached the ceiling: hold there and keep flagging
            verdict_d = IV_BAD;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign verdict_o = verdict_d;
    assign cnt_o     = st_q.cnt;

endmodule

// File: rtl/wdg_run.sv
module wdg_run
    import wdg_pkg::*;
#(
    parameter int GOOD_RUN = 16,
    localparam int GW = $clog2(GOOD_RUN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  ivl_verdict_e  verdict_i,
    input  logic          fault_out_on,
    output logic          fail_o,
    output logic          ok_o,
    output logic [GW-1:0] good_o
);
    localparam logic [GW-1:0] RUN_V = GW'(GOOD_RUN);

    typedef struct packed {
        logic [GW-1:0] good;
        logic          fail;
    } run_state_t;

    run_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = '0;
        end else begin
            case (verdict_i)
                IV_BAD: begin
                    st_d.good = '0;
                    st_d.fail = 1'b1;
                end
                IV_GOOD: begin
                    if (st_q.good != RUN_V) st_d.good = st_q.good + GW'(1);
                    if (st_d.good == RUN_V) st_d.fail = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fail_o = st_q.fail;
    assign ok_o   = en && fault_out_on && (st_q.good == RUN_V);
    assign good_o = st_q.good;

endmodule

// File: rtl/wdg_window_monitor.sv
module wdg_window_monitor
    import wdg_pkg::*;
#(
    parameter int LO_CYC   = 26,
    parameter int HI_CYC   = 89,
    parameter int GOOD_RUN = 16,
    parameter int SYNC_STG = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic trig_in,
    input  logic fault_out_on,
    output logic fail_req,
    output logic ok_req
);
    localparam int CW = $clog2(HI_CYC + 1);
    localparam int GW = $clog2(GOOD_RUN + 1);

    logic          edge_w;
    ivl_verdict_e  verdict_w;
    logic [CW-1:0] cnt_w;
    logic [GW-1:0] good_w;

    wdg_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (trig_in),
        .edge_o  (edge_w)
    );

    wdg_interval #(.LO_CYC(LO_CYC), .HI_CYC(HI_CYC)) u_ivl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .edge_i    (edge_w),
        .verdict_o (verdict_w),
        .cnt_o     (cnt_w)
    );

    wdg_run #(.GOOD_RUN(GOOD_RUN)) u_run (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .verdict_i    (verdict_w),
        .fault_out_on (fault_out_on),
        .fail_o       (fail_req),
        .ok_o         (ok_req),
        .good_o       (good_w)
    );

endmodule

// File: rtl/wdg_window_checker.sv
module wdg_window_checker #(
    parameter int HI_CYC   = 89,
    parameter int GOOD_RUN = 16,
    localparam int CW = $clog2(HI_CYC + 1),
    localparam int GW = $clog2(GOOD_RUN + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          edge_seen,
    input logic [CW-1:0] cnt,
    input logic [GW-1:0] good,
    input logic          fail_req,
    input logic          ok_req
);
    a_r6_cnt_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(HI_CYC));

    a_r8_run_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        good <= GW'(GOOD_RUN));

    a_r3_timeout_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !edge_seen && cnt == CW'(HI_CYC)) |=> fail_req);

    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(fail_req && ok_req));

    a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!fail_req && cnt == '0 && good == '0));

endmodule

bind wdg_window_monitor wdg_window_checker #(
    .HI_CYC   (HI_CYC),
    .GOOD_RUN (GOOD_RUN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .edge_seen (edge_w),
    .cnt       (cnt_w),
    .good      (good_w),
    .fail_req  (fail_req),
    .ok_req    (ok_req)
);

// File: tb/sim_wdg_window_monitor.sv
module sim_wdg_window_monitor;
    localparam int LO  = 26;
    localparam int HI  = 89;
    localparam int RUN = 16;
    localparam int NV  = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic trig = 1'b0;
    logic fout = 1'b0;
    logic fail_req, ok_req;
    int   n_chk = 0;
    int   n_fail = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    wdg_window_monitor #(.LO_CYC(LO), .HI_CYC(HI), .GOOD_RUN(RUN)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .trig_in(trig),
        .fault_out_on(fout), .fail_req(fail_req), .ok_req(ok_req)
    );

    // gap between toggles, repetitions, expected fail_req / ok_req after each
    typedef struct packed {
        int   gap;
        int   reps;
        logic fail;
        logic ok;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{50, 15, 1'b1, 1'b0},   // R5 good, run incomplete
        '{50,  1, 1'b0, 1'b1},   // R7 run complete
        '{50,  3, 1'b0, 1'b1},   // R7 stays recovered
        '{10,  1, 1'b1, 1'b0},   // R4 short
        '{50, 15, 1'b1, 1'b0},   // R8 run restarted
        '{26,  1, 1'b1, 1'b0},   // R4 exactly LO, breaks run (R8)
        '{50, 15, 1'b1, 1'b0},   // R8
        '{100, 1, 1'b1, 1'b0},   // R3 long
        '{27, 15, 1'b1, 1'b0},   // R5 LO+1 good
        '{88,  1, 1'b0, 1'b1},   // R5 HI-1 good completes run
        '{89,  1, 1'b1, 1'b0},   // R3 exactly HI
        '{50, 15, 1'b1, 1'b0},   // R2 edges of both polarities count
        '{50,  1, 1'b0, 1'b1}    // R7
    };
    string VTAG [NV] = '{"R5", "R7", "R7", "R4", "R8", "R4", "R8",
                         "R3", "R5", "R5", "R3", "R2", "R7"};

    task automatic chk(string tag, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // precondition: last toggle was 4 cycles ago
    task automatic step(int gap, logic ef, logic eo, string tag);
        cyc(gap - 4);
        trig = ~trig;
        cyc(4);
        chk(tag, "fail_req", fail_req, ef);
        chk(tag, "ok_req", ok_req, eo);
    endtask

    initial begin
        cyc(3);
        chk("R1", "fail_req in reset", fail_req, 1'b0);
        chk("R1", "ok_req in reset", ok_req, 1'b0);
        rst_n = 1'b1;
        cyc(2);
        chk("R1", "fail_req after reset", fail_req, 1'b0);

        // missing trigger from enable
        en = 1'b1; fout = 1'b1;
        cyc(HI + 10);
        chk("R3", "fail_req on silence", fail_req, 1'b1);
        trig = ~trig;             // first edge, unclassified
        cyc(4);

        for (int v = 0; v < NV; v++) begin
            for (int r = 0; r < VECS[v].reps; r++)
                step(VECS[v].gap, VECS[v].fail, VECS[v].ok, VTAG[v]);
        end

        // R11: fault output off gates ok_req only
        fout = 1'b0;
        cyc(1);
        chk("R11", "ok_req gated", ok_req, 1'b0);
        step(10, 1'b1, 1'b0, "R11");
        for (int r = 0; r < RUN - 1; r++) step(50, 1'b1, 1'b0, "R11");
        step(50, 1'b0, 1'b0, "R11");
        fout = 1'b1;

        // R9: disable clears and ignores trigger
        step(10, 1'b1, 1'b0, "R9");
        en = 1'b0;
        cyc(1);
        chk("R9", "fail_req cleared", fail_req, 1'b0);
        chk("R9", "ok_req low", ok_req, 1'b0);
        for (int i = 0; i < 20; i++) begin
            trig = ~trig;
            cyc(2);
        end
        cyc(200);
        chk("R9", "fail_req while disabled", fail_req, 1'b0);

        // R10: first edge after enable is not judged even though short
        en = 1'b1;
        cyc(3);
        trig = ~trig;
        cyc(4);
        chk("R10", "first edge unclassified", fail_req, 1'b0);
        step(50, 1'b0, 1'b0, "R10");

        // R6: long silence must not wrap into a good reading
        cyc(178 - 4);
        trig = ~trig;
        cyc(4);
        chk("R6", "long silence fails", fail_req, 1'b1);
        for (int r = 0; r < RUN - 1; r++) step(50, 1'b1, 1'b0, "R6");
        step(50, 1'b0, 1'b1, "R6");

        // R1: reset mid-run
        rst_n = 1'b0;
        cyc(1);
        chk("R1", "ok_req on reset", ok_req, 1'b0);
        chk("R1", "fail_req on reset", fail_req, 1'b0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: got running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule